// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a single asynchronous serial line into whole characters. It is clocked by the system clock and paced by a one-cycle baud strobe at sixteen times the bit rate; baud generation happens elsewhere. The serial input first passes through a two-stage synchronizer. A framing engine then hunts for a falling edge and confirms the start bit at mid-bit. It samples each following bit at its centre, least significant bit first, through five to eight data bits, an optional parity bit and one stop bit.

A finished character is placed in a single-entry holding stage together with its parity and framing flags. It is offered on a valid/ready output. `char_valid` rises at the middle of the stop bit and stays high, with data and flags unchanged, until the consumer raises `char_ready` in the same cycle; that cycle is the pop. A character that finishes while the holding stage is full, and is not popped in that same cycle, is dropped and sets a sticky overrun flag. A character finishing in the very cycle of a pop takes the freed slot. `rx_enable` low keeps the engine idle, so any line activity is lost. A one-cycle `rx_clear` command wipes the engine, the holding stage and every flag.

Top module: `uart_rx_engine`

## Requirements
- R1: A falling edge seen at a baud strobe arms start detection. The line is checked again on the 8th strobe after that edge. If it is high again, the start bit is rejected and no character is produced.
- R2: After a valid start, each bit is sampled every 16 strobes. The first data bit received becomes bit 0 of `char_data`.
- R3: `len_sel` picks the data length as 5 + `len_sel` bits (00=5, 01=6, 10=7, 11=8). Bits of `char_data` above the chosen length read as zero.
- R4: With `parity_en` high, one parity bit follows the data. `parity_odd`=0 asks for an even count of ones over data plus parity, and 1 asks for an odd count. A mismatch sets `char_par_err`, which is carried with that character. With `parity_en` low, `char_par_err` is 0.
- R5: `char_valid` rises at the stop-bit sample, about half a bit into the stop bit. The engine at once looks for the next start, so frames sent back to back are all received.
- R6: A low stop-bit sample delivers the character with `char_frm_err` set.
- R7: After a framing error on nonzero data, if the line is still low 8 strobes past the stop sample, that low is treated as a freshly detected start bit, and the character that follows is received.
- R8: After a framing error on all-zero data, no new start is accepted until the line has gone high and then falls again.
- R9: While `char_valid` is high and `char_ready` is low, `char_valid`, `char_data` and both flags hold. A cycle with both high pops the entry.
- R10: A character that completes while the entry is full and not being popped is discarded, and `overrun` is set. It stays set until `rx_clear`.
- R11: While `rx_enable` is low, the line is ignored and no character is produced.
- R12: `rx_clear` high for one cycle leaves `char_valid` and `overrun` low on the next cycle and returns the engine to start-bit search.
- R13: After `rst_n` release, `char_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Receiver enable |
| rx_clear | input | 1 | Reset command, clears receiver and status |
| len_sel | input | 2 | Data length code, length = 5 + code |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| char_valid | output | 1 | Holding entry contains a character |
| char_ready | input | 1 | Consumer accepts the entry this cycle |
| char_data | output | 8 | Received character, zero-extended |
| char_par_err | output | 1 | Parity error of the held character |
| char_frm_err | output | 1 | Framing error of the held character |
| overrun | output | 1 | Sticky: a character was lost to a full entry |

## Verification
Four things are checked on every cycle by the assertions. The output holds while stalled. Overrun stays set until cleared. The clear command empties everything in one cycle. Each finished character is a single-cycle pulse, zero above its length, and none is produced while the receiver is disabled. Only the bench's scenarios can show the rest. These are the serial-side behaviours: rejection of a short start glitch, bit order, parity sense, when ready rises within the stop bit, the restart after a framing error on nonzero data versus the wait for a high line after an all-zero break, and the loss of characters sent while disabled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HUNT
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  // Idle level of the line is high, so reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OSR      = 16,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              pe,
  output logic              fe
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              last_lvl;
  logic              par_acc;

  logic [BIT_W-1:0]  nbits;
  logic [BIT_W-1:0]  shamt;
  logic [DATA_W-1:0] aligned;

  // Bits enter at the top and move down; a short character is right-aligned
  // by shifting out the unused positions, which leaves zeros above it.
  assign nbits   = BIT_W'(MIN_BITS) + BIT_W'(len_code);
  assign shamt   = BIT_W'(DATA_W) - nbits;
  assign aligned = shreg >> shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      last_lvl <= 1'b1;
      par_acc  <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      pe       <= 1'b0;
      fe       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr || !en) begin
        state <= ST_IDLE;
        cnt   <= '0;
        bitn  <= '0;
        shreg <= '0;
        if (clr)       last_lvl <= 1'b1;
        else if (tick) last_lvl <= line;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            last_lvl <= line;
            if (last_lvl && !line) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == HALF_M1) begin
              cnt <= '0;
              if (line) begin
                state    <= ST_IDLE;
                last_lvl <= 1'b1;
              end else begin
                state   <= ST_DATA;
                bitn    <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == FULL_M1) begin
              cnt     <= '0;
              shreg   <= {line, shreg[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              bitn    <= bitn + 1'b1;
              if (bitn == nbits - BIT_W'(1))
                state <= par_en ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == FULL_M1) begin
              cnt     <= '0;
              par_acc <= par_acc ^ line;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == FULL_M1) begin
              cnt  <= '0;
              done <= 1'b1;
              data <= aligned;
              pe   <= par_en && (par_acc ^ par_odd);
              fe   <= !line;
              if (line) begin
                state    <= ST_IDLE;
                last_lvl <= 1'b1;
              end else if (aligned != '0) begin
                state <= ST_HUNT;
              end else begin
                // Break: wait for the line to return high first.
                state    <= ST_IDLE;
                last_lvl <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_HUNT: begin
            if (cnt == HALF_M1) begin
              cnt <= '0;
              if (!line) begin
                state <= ST_START;
              end else begin
                state    <= ST_IDLE;
                last_lvl <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_NO_CHAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((data >> nbits) == '0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == ST_IDLE) && !done); // R12
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_pe,
  input  logic              ld_fe,
  output logic              valid,
  input  logic              ready,
  output logic [DATA_W-1:0] data,
  output logic              pe,
  output logic              fe,
  output logic              ovr
);
  logic pop;
  assign pop = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      pe    <= 1'b0;
      fe    <= 1'b0;
      ovr   <= 1'b0;
    end else if (clr) begin
      valid <= 1'b0;
      data  <= '0;
      pe    <= 1'b0;
      fe    <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (load && (!valid || pop)) begin
        valid <= 1'b1;
        data  <= ld_data;
        pe    <= ld_pe;
        fe    <= ld_fe;
      end else if (pop) begin
        valid <= 1'b0;
      end
      if (load && valid && !pop) ovr <= 1'b1;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !clr) |=> valid && $stable(data) && $stable(pe) && $stable(fe)); // R9
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid && !ovr); // R12
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine #(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int LEN_W     = 2,
  parameter int MIN_BITS  = 5,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic              rx_enable,
  input  logic              rx_clear,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              parity_en,
  input  logic              parity_odd,
  output logic              char_valid,
  input  logic              char_ready,
  output logic [DATA_W-1:0] char_data,
  output logic              char_par_err,
  output logic              char_frm_err,
  output logic              overrun
);
  logic              line_s;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_pe;
  logic              f_fe;

  rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  rx_framer #(
    .DATA_W  (DATA_W),
    .OSR     (OSR),
    .LEN_W   (LEN_W),
    .MIN_BITS(MIN_BITS)
  ) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rx_clear),
    .en      (rx_enable),
    .tick    (baud_tick),
    .line    (line_s),
    .len_code(len_sel),
    .par_en  (parity_en),
    .par_odd (parity_odd),
    .done    (f_done),
    .data    (f_data),
    .pe      (f_pe),
    .fe      (f_fe)
  );

  rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rx_clear),
    .load   (f_done),
    .ld_data(f_data),
    .ld_pe  (f_pe),
    .ld_fe  (f_fe),
    .valid  (char_valid),
    .ready  (char_ready),
    .data   (char_data),
    .pe     (char_par_err),
    .fe     (char_frm_err),
    .ovr    (overrun)
  );
endmodule

// File: tb/uart_rx_engine_test.sv
module uart_rx_engine_test;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       rx_enable = 1'b1;
  logic       rx_clear = 1'b0;
  logic [1:0] len_sel = 2'b11;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       char_ready = 1'b0;
  logic       char_valid;
  logic [7:0] char_data;
  logic       char_par_err;
  logic       char_frm_err;
  logic       overrun;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  uart_rx_engine uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .rx_enable(rx_enable), .rx_clear(rx_clear), .len_sel(len_sel),
    .parity_en(parity_en), .parity_odd(parity_odd), .char_valid(char_valid),
    .char_ready(char_ready), .char_data(char_data), .char_par_err(char_par_err),
    .char_frm_err(char_frm_err), .overrun(overrun)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bitw(input logic lv);
    rx_line = lv;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic idle(input int nb);
    for (int i = 0; i < nb; i++) bitw(1'b1);
  endtask

  function automatic logic xor_of(input logic [7:0] d, input int nb);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    return x;
  endfunction

  task automatic send(input logic [7:0] d, input int nb, input bit use_par,
                      input logic pbit, input logic stop_lv);
    bitw(1'b0);
    for (int i = 0; i < nb; i++) bitw(d[i]);
    if (use_par) bitw(pbit);
    bitw(stop_lv);
  endtask

  task automatic pop_expect(input logic [7:0] d, input logic p, input logic f, input string req);
    check(char_valid === 1'b1, {req, " valid"}, int'(char_valid), 1);
    check(char_data === d, {req, " data"}, int'(char_data), int'(d));
    check(char_par_err === p, {req, " parity flag"}, int'(char_par_err), int'(p));
    check(char_frm_err === f, {req, " framing flag"}, int'(char_frm_err), int'(f));
    char_ready = 1'b1;
    @(negedge clk);
    char_ready = 1'b0;
    check(char_valid === 1'b0, {req, " pop empties"}, int'(char_valid), 0);
  endtask

  task automatic t_reset_state;
    check(char_valid === 1'b0, "R13 valid after reset", int'(char_valid), 0);
    check(overrun === 1'b0, "R13 overrun after reset", int'(overrun), 0);
  endtask

  task automatic t_basic_8bit;
    len_sel = 2'b11;
    send(8'hA5, 8, 0, 0, 1); idle(1);
    pop_expect(8'hA5, 0, 0, "R2 0xA5");
    send(8'h3C, 8, 0, 0, 1); idle(1);
    pop_expect(8'h3C, 0, 0, "R2 0x3C");
  endtask

  task automatic t_lengths;
    len_sel = 2'b00;
    send(8'h15, 5, 0, 0, 1); idle(1);
    pop_expect(8'h15, 0, 0, "R3 5-bit");
    len_sel = 2'b10;
    send(8'h5B, 7, 0, 0, 1); idle(1);
    pop_expect(8'h5B, 0, 0, "R3 7-bit");
    len_sel = 2'b11;
  endtask

  task automatic t_parity;
    logic x = xor_of(8'h0B, 8);
    parity_en = 1'b1;
    parity_odd = 1'b0;
    send(8'h0B, 8, 1, x, 1); idle(1);
    pop_expect(8'h0B, 0, 0, "R4 even good");
    send(8'h0B, 8, 1, ~x, 1); idle(1);
    pop_expect(8'h0B, 1, 0, "R4 even bad");
    parity_odd = 1'b1;
    send(8'h0B, 8, 1, ~x, 1); idle(1);
    pop_expect(8'h0B, 0, 0, "R4 odd good");
    send(8'h0B, 8, 1, x, 1); idle(1);
    pop_expect(8'h0B, 1, 0, "R4 odd bad");
    parity_en = 1'b0;
    parity_odd = 1'b0;
  endtask

  task automatic t_glitch;
    rx_line = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    idle(3);
    check(char_valid === 1'b0, "R1 short low rejected", int'(char_valid), 0);
    send(8'h66, 8, 0, 0, 1); idle(1);
    pop_expect(8'h66, 0, 0, "R1 after glitch");
  endtask

  task automatic t_ready_timing;
    logic [7:0] d = 8'h81;
    bitw(1'b0);
    for (int i = 0; i < 8; i++) bitw(d[i]);
    rx_line = 1'b1;
    repeat (5 * TICK_DIV) @(negedge clk);
    check(char_valid === 1'b0, "R5 not ready early in stop", int'(char_valid), 0);
    repeat (8 * TICK_DIV) @(negedge clk);
    check(char_valid === 1'b1, "R5 ready by stop midpoint", int'(char_valid), 1);
    repeat (3 * TICK_DIV) @(negedge clk);
    pop_expect(8'h81, 0, 0, "R5 char");
    idle(1);
  endtask

  task automatic t_back_to_back;
    send(8'h12, 8, 0, 0, 1);
    pop_expect(8'h12, 0, 0, "R5 first of pair");
    send(8'h34, 8, 0, 0, 1); idle(1);
    pop_expect(8'h34, 0, 0, "R5 second of pair");
  endtask

  task automatic t_frame_restart;
    send(8'h5A, 8, 0, 0, 0);
    pop_expect(8'h5A, 0, 1, "R6 framing flag");
    send(8'h3C, 8, 0, 0, 1); idle(1);
    pop_expect(8'h3C, 0, 0, "R7 restart char");
  endtask

  task automatic t_break;
    send(8'h00, 8, 0, 0, 0);
    bitw(1'b0); bitw(1'b0); bitw(1'b0);
    pop_expect(8'h00, 0, 1, "R8 break char");
    idle(2);
    check(char_valid === 1'b0, "R8 no char from break low", int'(char_valid), 0);
    send(8'h77, 8, 0, 0, 1); idle(1);
    pop_expect(8'h77, 0, 0, "R8 recovery");
  endtask

  task automatic t_overrun;
    send(8'h11, 8, 0, 0, 1); idle(1);
    send(8'h22, 8, 0, 0, 1); idle(1);
    check(overrun === 1'b1, "R10 overrun set", int'(overrun), 1);
    pop_expect(8'h11, 0, 0, "R10 first kept");
    check(overrun === 1'b1, "R10 overrun sticky", int'(overrun), 1);
  endtask

  task automatic t_clear;
    send(8'h33, 8, 0, 0, 1); idle(1);
    check(char_valid === 1'b1, "R12 entry full before clear", int'(char_valid), 1);
    rx_clear = 1'b1;
    @(negedge clk);
    rx_clear = 1'b0;
    check(char_valid === 1'b0, "R12 valid cleared", int'(char_valid), 0);
    check(overrun === 1'b0, "R12 overrun cleared", int'(overrun), 0);
    send(8'h4E, 8, 0, 0, 1); idle(1);
    pop_expect(8'h4E, 0, 0, "R12 receives after clear");
  endtask

  task automatic t_disabled;
    rx_enable = 1'b0;
    send(8'h44, 8, 0, 0, 1); idle(1);
    rx_enable = 1'b1;
    idle(2);
    check(char_valid === 1'b0, "R11 char lost while disabled", int'(char_valid), 0);
    send(8'h55, 8, 0, 0, 1); idle(1);
    pop_expect(8'h55, 0, 0, "R11 after enable");
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    idle(1);
    t_basic_8bit();
    t_lengths();
    t_parity();
    t_glitch();
    t_ready_timing();
    t_back_to_back();
    t_frame_restart();
    t_break();
    t_overrun();
    t_clear();
    t_disabled();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      finish_run();
    end
  end
endmodule